// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Converter and Timer Arbitration

This block is an 8-pin general-purpose I/O port whose pins double as analog converter channel inputs. The two highest pins also carry two timer capture/compare channels. Software reaches two registers over a plain register bus: a per-pin output value register and a per-pin direction register. The block works out which function owns each pin. It then drives the pad output value and output enable, routes the pad state to the converter or the timer, and forms the register read-back under the rule that applies to that owner.

Ownership follows a fixed priority. The converter comes first, then the timer, then GPIO. The converter owns the one pin named by its channel-select input, if any. A timer channel owns its pin whenever that channel's 2-bit mode-select field is nonzero. The direction register never sets the pad direction of a pin that the converter or the timer owns. It still picks what a read of that pin returns. All pad inputs pass through a two-flop synchronizer before they reach the read-back path or the timer.

The register bus has no back-pressure. A write completes in the cycle it is presented. Read data is combinational from the address. Control inputs from the converter and timer are plain level signals.

Top module: `gpiox_port`

## Requirements
- R1: A bus write to address 0x1 loads the 8-bit output-value register. A read of 0x1 returns the stored bit for every pin whose direction bit is 1 (output), whatever function owns that pin.
- R2: The direction register sits at address 0x5, bit i controls pin i (1 = output), and it resets to 0x00. Reset does not change the output-value register.
- R3: For a GPIO-owned pin, pad_oe equals the direction bit and pad_out equals the output-value bit.
- R4: Reading 0x1 for a GPIO-owned pin with direction bit 0 returns the pad state after a two-flop synchronizer. A change at the pad shows in the read-back after the second rising clock edge.
- R5: A conv_chsel value of 0 to 7 gives the converter ownership of the pin with that index. Any value of 8 or more gives it no pin. A converter-owned pin has pad_oe = 0 and pad_out = 0, and conv_in carries that pin's raw pad value (0 when no pin is selected).
- R6: Reading 0x1 for a converter-owned pin with direction bit 0 returns 0.
- R7: Pin 6 belongs to timer channel 0 and pin 7 to timer channel 1 when the channel's mode-select field is nonzero. In compare mode (tmr_oc bit = 1), the pin drives tmr_out with pad_oe = 1. In capture mode, pad_oe = 0 and tmr_cap carries the synchronized pad state. tmr_cap is 0 for a channel that does not own its pin.
- R8: Reading 0x1 for a timer-owned pin with direction bit 0 returns the synchronized pad state.
- R9: When the converter selects a pin that a timer channel also claims, the converter wins. pad_oe and pad_out of that pin are 0, and that channel's tmr_cap is 0.
- R10: Writes to any address other than 0x1 and 0x5 change no register. Reads of such addresses return 0x00, and so does any read with bus_sel low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| conv_chsel | input | 5 | Converter channel select |
| conv_in | output | 1 | Raw pad value of the converter-owned pin |
| tmr_mode | input | 4 | Mode-select fields: [1:0] channel 0, [3:2] channel 1 |
| tmr_oc | input | 2 | Per channel: 1 = compare (drive), 0 = capture |
| tmr_out | input | 2 | Per-channel compare output value |
| tmr_cap | output | 2 | Per-channel synchronized capture input |
| pad_in | input | 8 | Pad input state |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |

## Verification
On every cycle, the assertions check that a converter-owned pin never has its output enabled and reads back as zero when its direction bit is input. They also check that a compare-mode timer pin not taken by the converter drives the timer's value, and that the direction-only pins come out of reset with outputs disabled. Only the bench's scenarios can show the two-cycle synchronizer latency, the survival of the output-value register across reset, the read-back mix across owners, and that writes to unused addresses leave both registers intact.

// File: rtl/gpiox_pkg.sv
package gpiox_pkg;
  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_TMR  = 2'd1,
    OWN_CONV = 2'd2
  } owner_e;

  localparam logic [3:0] ADDR_VAL = 4'h1;
  localparam logic [3:0] ADDR_DIR = 4'h5;
endpackage

// File: rtl/gpiox_regs.sv
module gpiox_regs #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  val_q,
  output logic [W-1:0]  dir_q
);
  import gpiox_pkg::*;

  logic wr_val, wr_dir;
  assign wr_val = bus_sel && bus_wr && (bus_addr == AW'(ADDR_VAL));
  assign wr_dir = bus_sel && bus_wr && (bus_addr == AW'(ADDR_DIR));

  // output-value register keeps its content through reset
  always_ff @(posedge clk) begin
    if (wr_val) val_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= bus_wdata;
  end
endmodule

// File: rtl/gpiox_sync.sv
module gpiox_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpiox_owner.sv
module gpiox_owner
  import gpiox_pkg::*;
#(
  parameter int W        = 8,
  parameter int CSW      = 5,
  parameter int TMR_N    = 2,
  parameter int TMR_BASE = W - TMR_N
) (
  input  logic [CSW-1:0]     conv_chsel,
  input  logic [2*TMR_N-1:0] tmr_mode,
  input  logic [TMR_N-1:0]   tmr_oc,
  input  logic [TMR_N-1:0]   tmr_out,
  input  logic [W-1:0]       val_q,
  input  logic [W-1:0]       dir_q,
  input  logic [W-1:0]       pin_sync,
  input  logic [W-1:0]       pad_in,
  output owner_e [W-1:0]     own,
  output logic [W-1:0]       pad_out,
  output logic [W-1:0]       pad_oe,
  output logic [TMR_N-1:0]   tmr_cap,
  output logic               conv_in
);
  localparam int IDXW = $clog2(W);

  logic conv_any;
  assign conv_any = (conv_chsel < CSW'(W));
  assign conv_in  = conv_any ? pad_in[conv_chsel[IDXW-1:0]] : 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic conv_hit, tmr_hit, tmr_drive, tmr_val;
    assign conv_hit = conv_any && (conv_chsel == CSW'(i));
    if (i >= TMR_BASE && i < TMR_BASE + TMR_N) begin : g_tmr
      localparam int K = i - TMR_BASE;
      assign tmr_hit   = (tmr_mode[2*K +: 2] != 2'b00);
      assign tmr_drive = tmr_oc[K];
      assign tmr_val   = tmr_out[K];
    end else begin : g_plain
      assign tmr_hit   = 1'b0;
      assign tmr_drive = 1'b0;
      assign tmr_val   = 1'b0;
    end

    always_comb begin
      if (conv_hit) begin
        own[i]     = OWN_CONV;
        pad_oe[i]  = 1'b0;
        pad_out[i] = 1'b0;
      end else if (tmr_hit) begin
        own[i]     = OWN_TMR;
        pad_oe[i]  = tmr_drive;
        pad_out[i] = tmr_drive & tmr_val;
      end else begin
        own[i]     = OWN_GPIO;
        pad_oe[i]  = dir_q[i];
        pad_out[i] = val_q[i];
      end
    end
  end

  for (genvar k = 0; k < TMR_N; k++) begin : g_cap
    assign tmr_cap[k] = (own[TMR_BASE+k] == OWN_TMR) && !tmr_oc[k] && pin_sync[TMR_BASE+k];
  end
endmodule

// File: rtl/gpiox_readmux.sv
module gpiox_readmux
  import gpiox_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          bus_sel,
  input  logic [AW-1:0] bus_addr,
  input  owner_e [W-1:0] own,
  input  logic [W-1:0]  val_q,
  input  logic [W-1:0]  dir_q,
  input  logic [W-1:0]  pin_sync,
  output logic [W-1:0]  bus_rdata
);
  logic [W-1:0] port_view;

  for (genvar i = 0; i < W; i++) begin : g_view
    always_comb begin
      if (dir_q[i])               port_view[i] = val_q[i];
      else if (own[i] == OWN_CONV) port_view[i] = 1'b0;
      else                         port_view[i] = pin_sync[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == AW'(ADDR_VAL))      bus_rdata = port_view;
      else if (bus_addr == AW'(ADDR_DIR)) bus_rdata = dir_q;
    end
  end
endmodule

// File: rtl/gpiox_port.sv
module gpiox_port #(
  parameter int W        = 8,
  parameter int AW       = 4,
  parameter int CSW      = 5,
  parameter int TMR_N    = 2,
  parameter int SYNC_STG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [W-1:0]       bus_wdata,
  output logic [W-1:0]       bus_rdata,
  input  logic [CSW-1:0]     conv_chsel,
  output logic               conv_in,
  input  logic [2*TMR_N-1:0] tmr_mode,
  input  logic [TMR_N-1:0]   tmr_oc,
  input  logic [TMR_N-1:0]   tmr_out,
  output logic [TMR_N-1:0]   tmr_cap,
  input  logic [W-1:0]       pad_in,
  output logic [W-1:0]       pad_out,
  output logic [W-1:0]       pad_oe
);
  import gpiox_pkg::*;

  logic [W-1:0]   val_q;
  logic [W-1:0]   dir_q;
  logic [W-1:0]   pin_sync;
  owner_e [W-1:0] own;

  gpiox_regs #(.W(W), .AW(AW)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .val_q(val_q), .dir_q(dir_q)
  );

  gpiox_sync #(.W(W), .STAGES(SYNC_STG)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpiox_owner #(.W(W), .CSW(CSW), .TMR_N(TMR_N)) i_owner (
    .conv_chsel(conv_chsel), .tmr_mode(tmr_mode), .tmr_oc(tmr_oc),
    .tmr_out(tmr_out), .val_q(val_q), .dir_q(dir_q), .pin_sync(pin_sync),
    .pad_in(pad_in), .own(own), .pad_out(pad_out), .pad_oe(pad_oe),
    .tmr_cap(tmr_cap), .conv_in(conv_in)
  );

  gpiox_readmux #(.W(W), .AW(AW)) i_rmux (
    .bus_sel(bus_sel), .bus_addr(bus_addr), .own(own), .val_q(val_q),
    .dir_q(dir_q), .pin_sync(pin_sync), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/gpiox_port_chk.sv
module gpiox_port_chk #(
  parameter int W   = 8,
  parameter int AW  = 4,
  parameter int CSW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [W-1:0]   bus_rdata,
  input logic [CSW-1:0] conv_chsel,
  input logic [3:0]     tmr_mode,
  input logic [1:0]     tmr_oc,
  input logic [1:0]     tmr_out,
  input logic [1:0]     tmr_cap,
  input logic [W-1:0]   pad_out,
  input logic [W-1:0]   pad_oe,
  input logic [W-1:0]   dir_q
);
  localparam int IDXW = $clog2(W);

  AST_CONV_PIN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_chsel < CSW'(W)) |-> (!pad_oe[conv_chsel[IDXW-1:0]] && !pad_out[conv_chsel[IDXW-1:0]])); // R5

  AST_CONV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(1) && conv_chsel < CSW'(W) && !dir_q[conv_chsel[IDXW-1:0]])
      |-> !bus_rdata[conv_chsel[IDXW-1:0]]); // R6

  AST_TMR0_COMPARE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_mode[1:0] != 2'b00 && tmr_oc[0] && conv_chsel != CSW'(6))
      |-> (pad_oe[6] && pad_out[6] == tmr_out[0])); // R7

  AST_TMR1_LOSES_TO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_chsel == CSW'(7)) |-> (!tmr_cap[1] && !pad_oe[7])); // R9

  AST_DIR_RESET_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe[W-3:0] == '0)); // R2

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr != AW'(1) && bus_addr != AW'(5)) |-> (bus_rdata == '0)); // R10
endmodule

bind gpiox_port gpiox_port_chk #(.W(W), .AW(AW), .CSW(CSW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .conv_chsel(conv_chsel),
  .tmr_mode(tmr_mode), .tmr_oc(tmr_oc), .tmr_out(tmr_out), .tmr_cap(tmr_cap),
  .pad_out(pad_out), .pad_oe(pad_oe), .dir_q(dir_q)
);

// File: tb/test_gpiox_port.sv
module test_gpiox_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [4:0] conv_chsel = 5'd31;
  logic       conv_in;
  logic [3:0] tmr_mode = '0;
  logic [1:0] tmr_oc = '0, tmr_out = '0, tmr_cap;
  logic [7:0] pad_in = '0, pad_out, pad_oe;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpiox_port i_gpiox_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_chsel(conv_chsel), .conv_in(conv_in), .tmr_mode(tmr_mode),
    .tmr_oc(tmr_oc), .tmr_out(tmr_out), .tmr_cap(tmr_cap),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // val, dir, pad, chsel, mode, oc, tout | exp oe, out, rd, cap, cin
  typedef struct packed {
    logic [7:0] val; logic [7:0] dir; logic [7:0] pad; logic [4:0] chsel;
    logic [3:0] mode; logic [1:0] oc; logic [1:0] tout;
    logic [7:0] e_oe; logic [7:0] e_out; logic [7:0] e_rd; logic [1:0] e_cap; logic e_cin;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'hA5, 8'hF0, 8'h3C, 5'd31, 4'h0, 2'b00, 2'b00, 8'hF0, 8'hA5, 8'hAC, 2'b00, 1'b0}, // R3 R4 R1
    '{8'hFF, 8'h00, 8'hFF, 5'd2,  4'h0, 2'b00, 2'b00, 8'h00, 8'hFB, 8'hFB, 2'b00, 1'b1}, // R5 R6
    '{8'h0F, 8'h08, 8'h00, 5'd3,  4'h0, 2'b00, 2'b00, 8'h00, 8'h07, 8'h08, 2'b00, 1'b0}, // R5 R1
    '{8'h00, 8'h00, 8'h40, 5'd8,  4'h2, 2'b01, 2'b01, 8'h40, 8'h40, 8'h40, 2'b00, 1'b0}, // R7 R8
    '{8'h00, 8'h80, 8'h80, 5'd9,  4'h4, 2'b00, 2'b00, 8'h00, 8'h00, 8'h00, 2'b10, 1'b0}, // R7 R1
    '{8'hFF, 8'h00, 8'h80, 5'd7,  4'hC, 2'b10, 2'b10, 8'h00, 8'h7F, 8'h00, 2'b00, 1'b1}, // R9
    '{8'h55, 8'hFF, 8'hFF, 5'd6,  4'hA, 2'b11, 2'b11, 8'hBF, 8'h95, 8'h55, 2'b00, 1'b1}  // R9 R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    bus_read(4'h5, rd); check("R2 dir reset", rd, 8'h00);
    check("R2 oe after reset", pad_oe, 8'h00);

    // vector table
    for (int v = 0; v < NV; v++) begin
      bus_write(4'h1, VECS[v].val);
      bus_write(4'h5, VECS[v].dir);
      conv_chsel = VECS[v].chsel; tmr_mode = VECS[v].mode;
      tmr_oc = VECS[v].oc; tmr_out = VECS[v].tout; pad_in = VECS[v].pad;
      repeat (3) @(negedge clk);
      check("R3/R5/R7/R9 pad_oe", pad_oe, VECS[v].e_oe);
      check("R3/R5/R7/R9 pad_out", pad_out, VECS[v].e_out);
      bus_read(4'h1, rd); check("R1/R4/R6/R8 readback", rd, VECS[v].e_rd);
      check("R7/R9 tmr_cap", {6'd0, tmr_cap}, {6'd0, VECS[v].e_cap});
      check("R5 conv_in", {7'd0, conv_in}, {7'd0, VECS[v].e_cin});
    end

    // R4 synchronizer latency
    conv_chsel = 5'd31; tmr_mode = '0; tmr_oc = '0;
    bus_write(4'h5, 8'h00);
    pad_in = 8'h00; repeat (3) @(negedge clk);
    pad_in = 8'h21;
    @(negedge clk); bus_read(4'h1, rd); check("R4 one edge old", rd, 8'h00);
    @(negedge clk); bus_read(4'h1, rd); check("R4 two edges new", rd, 8'h21);

    // R10 unmapped address write ignored, read zero
    bus_write(4'h1, 8'h3C);
    bus_write(4'h5, 8'h0F);
    bus_write(4'h3, 8'hFF);
    bus_write(4'h4, 8'hF0);
    bus_read(4'h5, rd); check("R10 dir intact", rd, 8'h0F);
    check("R10 oe intact", pad_oe, 8'h0F);
    check("R10 out intact", pad_out, 8'h3C);
    bus_read(4'h3, rd); check("R10 unmapped read", rd, 8'h00);
    bus_addr = 4'h5; #1 check("R10 no sel read", bus_rdata, 8'h00);

    // R2 output-value register survives reset
    bus_write(4'h1, 8'h96);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R2 oe during reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(4'h5, rd); check("R2 dir cleared", rd, 8'h00);
    bus_write(4'h5, 8'hFF);
    bus_read(4'h1, rd); check("R2 value kept over reset", rd, 8'h96);
    check("R3 out kept over reset", pad_out, 8'h96);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule